// File: doc/BRIEF.md
# Skewed-Strobe Delay Test Sequencer

This block produces the timing for path-delay testing when the tester is slower than the device. It runs from a fast reference clock at the device's rated frequency. From that clock it derives three signals. The first is a slow vector-application clock whose period is N rated periods. The second is an enable that clocks the device flip-flops on every rated period. The third is an output-sampling strobe placed a programmable number of rated periods after each vector edge.

The whole vector set is run once per strobe position. On pass k (k = 1..N) the strobe sits k rated periods after the vector edge. One full run therefore lasts N × N × V rated cycles, where V is the vector count.

Software writes the speed-reduction factor and the vector count, then pulses start. The vector index and pass index outputs address external pattern memory. The done flag marks the end of the run.

Top module: `skew_strobe_seq`

## Requirements
- R1: After reset, slow_clk, ff_en, strobe, vec_idx, pass_idx and done are all 0, and they stay 0 until start is pulsed.
- R2: The factor n_factor is sampled on start. A value of 0 is used as 1, and any value above N_MAX (16) is used as N_MAX.
- R3: ff_en is 1 on every fast cycle of a run and 0 when the block is idle or done.
- R4: During a run, phase p counts 0..N-1 in fast cycles, with phase 0 in the first cycle after start and after every vector edge. slow_clk is 1 for phases p < ceil(N/2) and 0 otherwise, so its period is N fast cycles. For N = 1, slow_clk stays 1 for the whole run.
- R5: strobe is 1 for exactly one fast cycle per slow period, at phase p = pass_idx. pass_idx is 0-based, so pass k strobes at phase k-1. For N = 1 this means a strobe on every cycle of a single pass.
- R6: vec_idx and pass_idx change only on the cycle that enters phase 0. vec_idx counts 0..V-1 once per slow period. When it wraps to 0, pass_idx increments.
- R7: A run applies V vectors in each of N passes, so ff_en is high for exactly N·N·V cycles. On the last period of the run the indices keep their final values, V-1 and N-1.
- R8: done rises in the cycle after the final phase of the last vector of pass N and stays 1 until the next start. A start at any time, including mid-run, clears done, both indices and the phase, and begins a new run.
- R9: vec_count is sampled on start, and a value of 0 is used as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock at the rated frequency |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that latches the settings and begins a run |
| n_factor | input | 5 | Speed-reduction factor N |
| vec_count | input | 8 | Number of vectors per pass |
| slow_clk | output | 1 | Vector-application clock; rises on each vector edge |
| ff_en | output | 1 | Rated-rate clock enable for the device flip-flops |
| strobe | output | 1 | Output-sampling pulse, one fast cycle wide |
| vec_idx | output | 8 | Index of the vector being applied |
| pass_idx | output | 4 | 0-based pass index; the skew is pass_idx+1 rated periods |
| done | output | 1 | Run complete |

## Verification
The bench runs the sequencer with several settings:
- N = 1, which separates the at-speed degenerate case from the skewed cases.
- An odd N (3) and an even N (4), which expose errors in the slow-clock duty split and in the strobe phase.
- A large out-of-range N and N = 0, which confirm the clamping through the exact run length.
- vec_count = 0, which confirms the vector-count rule.

A restart in the middle of a run shows that start clears every counter. The idle period after done shows that nothing moves until the next start.

// File: rtl/skew_strobe_pkg.sv
// Package: shared helpers for the skewed-strobe sequencer.
// Assumes callers pass plain integer values and cast the result to their own width.
package skew_strobe_pkg;

    // Limit a value to the range lo..hi.
    function automatic int clamp_range(int val, int lo, int hi);
        if (val < lo) return lo;
        if (val > hi) return hi;
        return val;
    endfunction

endpackage

// File: rtl/skew_phase_ctr.sv
// Module: fast-cycle phase counter inside one slow period.
// Counts 0..n_eff-1 while a run is active and flags the final phase.
// Assumes n_eff is between 1 and N_MAX and is held stable during a run.
module skew_phase_ctr #(
    parameter int N_MAX = 16,
    localparam int NEW = $clog2(N_MAX + 1),
    localparam int PW  = $clog2(N_MAX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           run,
    input  logic [NEW-1:0] n_eff,
    output logic [PW-1:0]  phase,
    output logic           last
);

    // Final phase of the current slow period.
    always_comb begin
        last = run && (NEW'(phase) == n_eff - NEW'(1));
    end

    // Advance the phase and return to zero at the vector edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (start) begin
            phase <= '0;
        end else if (run) begin
            if (last) phase <= '0;
            else      phase <= phase + PW'(1);
        end
    end

    a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (NEW'(phase) < n_eff));

endmodule

// File: rtl/skew_seq_ctr.sv
// Module: vector and pass counters, plus the run and done state.
// The indices move only when the phase counter wraps, or on start.
// Assumes v_eff >= 1 and n_eff >= 1.
module skew_seq_ctr #(
    parameter int N_MAX = 16,
    parameter int VW    = 8,
    localparam int NEW = $clog2(N_MAX + 1),
    localparam int PW  = $clog2(N_MAX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           last,
    input  logic [NEW-1:0] n_eff,
    input  logic [VW-1:0]  v_eff,
    output logic [VW-1:0]  vec,
    output logic [PW-1:0]  pass,
    output logic           run,
    output logic           done
);

    logic last_vec;
    logic last_pass;

    // Detect the end of the vector set and the end of the final pass.
    always_comb begin
        last_vec  = (vec == v_eff - VW'(1));
        last_pass = (NEW'(pass) == n_eff - NEW'(1));
    end

    // Step the vector index, then the pass index, then finish the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec  <= '0;
            pass <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else if (start) begin
            vec  <= '0;
            pass <= '0;
            run  <= 1'b1;
            done <= 1'b0;
        end else if (last) begin
            if (!last_vec) begin
                vec <= vec + VW'(1);
            end else if (!last_pass) begin
                vec  <= '0;
                pass <= pass + PW'(1);
            end else begin
                run  <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r7_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (NEW'(pass) < n_eff));

    a_r3_idle_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !run);

endmodule

// File: rtl/skew_timing_gen.sv
// Module: decodes the phase into the slow clock, the flip-flop enable and the strobe.
// Purely combinational, driven from registered state.
// Assumes phase < n_eff and pass < n_eff.
module skew_timing_gen #(
    parameter int N_MAX = 16,
    localparam int NEW = $clog2(N_MAX + 1),
    localparam int PW  = $clog2(N_MAX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [NEW-1:0] n_eff,
    input  logic [PW-1:0]  phase,
    input  logic [PW-1:0]  pass,
    output logic           slow_clk,
    output logic           ff_en,
    output logic           strobe
);

    logic [NEW:0] half;

    // High for the first ceil(N/2) phases; the strobe sits at phase == pass.
    always_comb begin
        half     = ({1'b0, n_eff} + (NEW+1)'(1)) >> 1;
        slow_clk = run && ((NEW+1)'(phase) < half);
        ff_en    = run;
        strobe   = run && (phase == pass);
    end

    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (n_eff > NEW'(1))) |=> !strobe);

endmodule

// File: rtl/skew_strobe_seq.sv
// Module: top of the skewed-strobe delay test sequencer.
// Latches the factor and the vector count on start, then steps through
// N passes of V vectors, each pass moving the strobe one rated period later.
// Assumes start is a single-cycle pulse in the clk domain.
module skew_strobe_seq #(
    parameter int N_MAX = 16,
    parameter int NIW   = 5,
    parameter int VW    = 8,
    localparam int NEW = $clog2(N_MAX + 1),
    localparam int PW  = $clog2(N_MAX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NIW-1:0] n_factor,
    input  logic [VW-1:0]  vec_count,
    output logic           slow_clk,
    output logic           ff_en,
    output logic           strobe,
    output logic [VW-1:0]  vec_idx,
    output logic [PW-1:0]  pass_idx,
    output logic           done
);
    import skew_strobe_pkg::*;

    logic [NEW-1:0] n_eff;
    logic [VW-1:0]  v_eff;
    logic [PW-1:0]  phase;
    logic           last;
    logic           run;

    // Capture the clamped settings at the start of each run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_eff <= NEW'(1);
            v_eff <= VW'(1);
        end else if (start) begin
            n_eff <= NEW'(clamp_range(int'(n_factor), 1, N_MAX));
            v_eff <= (vec_count == '0) ? VW'(1) : vec_count;
        end
    end

    skew_phase_ctr #(.N_MAX(N_MAX)) i_phase (
        .clk(clk), .rst_n(rst_n), .start(start), .run(run),
        .n_eff(n_eff), .phase(phase), .last(last)
    );

    skew_seq_ctr #(.N_MAX(N_MAX), .VW(VW)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .last(last),
        .n_eff(n_eff), .v_eff(v_eff), .vec(vec_idx), .pass(pass_idx),
        .run(run), .done(done)
    );

    skew_timing_gen #(.N_MAX(N_MAX)) i_timing (
        .clk(clk), .rst_n(rst_n), .run(run), .n_eff(n_eff), .phase(phase),
        .pass(pass_idx), .slow_clk(slow_clk), .ff_en(ff_en), .strobe(strobe)
    );

    a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !last) |=> ($stable(vec_idx) && $stable(pass_idx)));

    a_r6_idx_at_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && !(vec_idx == $past(vec_idx))) |-> (phase == '0));

endmodule

// File: tb/test_skew_strobe_seq.sv
module test_skew_strobe_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] n_factor = '0;
    logic [7:0] vec_count = '0;
    logic       slow_clk, ff_en, strobe, done;
    logic [7:0] vec_idx;
    logic [3:0] pass_idx;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    skew_strobe_seq i_skew_strobe_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .n_factor(n_factor),
        .vec_count(vec_count), .slow_clk(slow_clk), .ff_en(ff_en),
        .strobe(strobe), .vec_idx(vec_idx), .pass_idx(pass_idx), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: a schedule of phases, vectors and passes.
    int m_n = 1, m_v = 1, m_ph = 0, m_vec = 0, m_pass = 0;
    bit m_run = 0, m_done = 0, m_valid = 0;

    always @(posedge clk) begin
        m_valid <= 1'b1;
        if (!rst_n) begin
            m_n = 1; m_v = 1; m_ph = 0; m_vec = 0; m_pass = 0; m_run = 0; m_done = 0;
        end else if (start) begin
            m_n = (n_factor == 0) ? 1 : ((n_factor > 16) ? 16 : int'(n_factor));
            m_v = (vec_count == 0) ? 1 : int'(vec_count);
            m_ph = 0; m_vec = 0; m_pass = 0; m_run = 1; m_done = 0;
        end else if (m_run) begin
            m_ph++;
            if (m_ph == m_n) begin
                if (m_vec + 1 < m_v) begin
                    m_ph = 0; m_vec++;
                end else if (m_pass + 1 < m_n) begin
                    m_ph = 0; m_vec = 0; m_pass++;
                end else begin
                    m_ph = 0; m_run = 0; m_done = 1;
                end
            end
        end
    end

    // Compare every output against the reference on each cycle.
    always @(negedge clk) begin
        if (m_valid) begin
            bit exp_slow, exp_strobe;
            exp_slow   = m_run && (m_ph < (m_n + 1) / 2);
            exp_strobe = m_run && (m_ph == m_pass);
            chk(ff_en == m_run, "R3 ff_en", int'(ff_en), int'(m_run));
            chk(slow_clk == exp_slow, "R4 slow_clk", int'(slow_clk), int'(exp_slow));
            chk(strobe == exp_strobe, "R5 strobe", int'(strobe), int'(exp_strobe));
            chk(int'(vec_idx) == m_vec, "R6 vec_idx", int'(vec_idx), m_vec);
            chk(int'(pass_idx) == m_pass, "R6 pass_idx", int'(pass_idx), m_pass);
            chk(done == m_done, "R8 done", int'(done), int'(m_done));
        end
    end

    task automatic pulse_start(input int n, input int v);
        @(negedge clk);
        n_factor  = 5'(n);
        vec_count = 8'(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Run to done and check the enable-cycle total and the strobe total.
    task automatic run_case(input int n, input int v, input int exp_len,
                            input int exp_strobes, input string req);
        int len = 0, nstr = 0, guard = 0;
        pulse_start(n, v);
        while (!done && guard < 20000) begin
            if (ff_en) len++;
            if (strobe) nstr++;
            guard++;
            @(negedge clk);
        end
        chk(len == exp_len, {req, " run length"}, len, exp_len);
        chk(nstr == exp_strobes, {req, " strobe count"}, nstr, exp_strobes);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs are quiet in reset.
        chk({slow_clk, ff_en, strobe, done} == 4'b0, "R1 reset flags",
            int'({slow_clk, ff_en, strobe, done}), 0);
        chk(vec_idx == 0 && pass_idx == 0, "R1 reset indices", int'(vec_idx), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(ff_en == 0 && done == 0, "R1 idle after reset", int'(ff_en), 0);

        run_case(1, 3, 3, 3, "R7 N=1");
        run_case(4, 5, 80, 20, "R7 N=4");
        run_case(3, 4, 36, 12, "R7 N=3");
        run_case(0, 3, 3, 3, "R2 N=0");
        run_case(20, 2, 512, 32, "R2 N=20");
        run_case(3, 0, 9, 3, "R9 V=0");

        // R8: done holds while idle.
        repeat (10) @(negedge clk);
        chk(done == 1, "R8 done held", int'(done), 1);
        chk(ff_en == 0, "R3 idle enable", int'(ff_en), 0);

        // R8: restart in the middle of a run.
        pulse_start(4, 6);
        repeat (37) @(negedge clk);
        run_case(2, 3, 12, 6, "R8 restart");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule